// File: doc/BRIEF.md
# Dual NFSR Keystream Core

This block is the bit-serial datapath of a lightweight stream cipher. Its 121 bits of state sit in two nonlinear feedback shift registers: a short one of 31 bits (S) and a long one of 90 bits (B). The short register is nonlinear and self-contained. Its lowest bit is also mixed into the feedback of the long register. A fixed Boolean output function reads taps from both registers and produces one keystream bit per cycle. That bit is presented combinationally from the current state.

An external sequencer drives the block. It writes initial key and IV material through a parallel load port. It can XOR a 120-bit key into the state through a key-add port, which also forces the top bit of S to one. It then steps the registers. While `mix_mode` is high, each step feeds the output bit back into both new register bits, which is the mixing style used during initialization. While `mix_mode` is low, the block runs in normal keystream mode. Phase counting, discarding of warm-up output and plaintext handling belong to the sequencer and are not part of this block.

Top module: `kscore_dual_nfsr`

## Requirements
- R1: While reset is asserted, both registers clear to zero. With an all-zero state, `z_out` is 0.
- R2: A step (step_en=1, load_en=0, kadd_en=0) moves S one place toward index 0. The new S[30] is the nonlinear function f1 of the old S. This function has 9 linear, 6 quadratic, 7 cubic and 10 quartic terms.
- R3: The same step moves B one place toward index 0. The new B[89] is the old S[0] XOR f2(B), where f2 has 5 linear, 7 quadratic, 2 cubic and 1 quartic term.
- R4: `z_out` equals L⊕Q⊕T⊕T' of the current state. It is combinational and is valid before the edge that consumes it.
- R5: When mix_mode=1, the step also XORs z into both new bits. When mix_mode=0, z is not fed back.
- R6: load_en=1 overwrites S with load_s and B with load_b on the next edge. This has priority over key-add and stepping.
- R7: kadd_en=1 (with load_en=0) acts on the next edge. It sets B[j] to B[j]^kadd_val[j] for j 0..89 and S[i] to S[i]^kadd_val[90+i] for i 0..29, and forces S[30] to 1. This has priority over stepping.
- R8: With no enable asserted, the state holds, and mix_mode has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Overwrite both registers |
| load_s | input | 31 | Value loaded into S |
| load_b | input | 90 | Value loaded into B |
| kadd_en | input | 1 | XOR key into state, force S[30]=1 |
| kadd_val | input | 120 | Key: bits 89..0 to B, 119..90 to S[29:0] |
| step_en | input | 1 | Shift both registers one place |
| mix_mode | input | 1 | 1: feed z back into both new bits |
| z_out | output | 1 | Keystream bit of the current state |
| state_s | output | 31 | Contents of S |
| state_b | output | 90 | Contents of B |

## Verification
The shift and mixing assertions assume that the three enables may be asserted in any combination. Each assertion therefore conditions on the highest-priority enable that is active. No assertion depends on the sequencer respecting phase lengths. The stimulus asserts enables alone and together, and it toggles mix_mode on idle cycles. The data it loads comes from random values plus all-zero and all-ones patterns, so the register contents stay arbitrary. The bench model evaluates every monomial from index tables and compares z and both registers on every cycle.

// File: rtl/kscore_pkg.sv
package kscore_pkg;
  localparam int S_LEN   = 31;
  localparam int B_LEN   = 90;
  localparam int KEY_LEN = (S_LEN - 1) + B_LEN;

  function automatic logic f1_next(input logic [S_LEN-1:0] s);
    logic lin, quad, cub, quart;
    lin   = s[0] ^ s[2] ^ s[5] ^ s[6] ^ s[15] ^ s[17] ^ s[18] ^ s[20] ^ s[25];
    quad  = (s[8] & s[18]) ^ (s[8] & s[20]) ^ (s[12] & s[21]) ^
            (s[14] & s[19]) ^ (s[17] & s[21]) ^ (s[20] & s[22]);
    cub   = (s[4] & s[12] & s[22]) ^ (s[8] & s[18] & s[22]) ^
            (s[4] & s[19] & s[22]) ^ (s[7] & s[20] & s[21]) ^
            (s[8] & s[20] & s[22]) ^ (s[12] & s[19] & s[22]) ^
            (s[20] & s[21] & s[22]);
    quart = (s[4] & s[7] & s[12] & s[21]) ^ (s[4] & s[7] & s[19] & s[21]) ^
            (s[4] & s[12] & s[21] & s[22]) ^ (s[4] & s[19] & s[21] & s[22]) ^
            (s[7] & s[8] & s[18] & s[21]) ^ (s[7] & s[8] & s[20] & s[21]) ^
            (s[7] & s[12] & s[19] & s[21]) ^ (s[8] & s[18] & s[21] & s[22]) ^
            (s[8] & s[20] & s[21] & s[22]) ^ (s[12] & s[19] & s[21] & s[22]);
    return lin ^ quad ^ cub ^ quart;
  endfunction

  function automatic logic f2_next(input logic [B_LEN-1:0] b);
    logic lin, hi;
    lin = b[0] ^ b[24] ^ b[49] ^ b[79] ^ b[84];
    hi  = (b[3] & b[59]) ^ (b[60] & b[74]) ^ (b[10] & b[12]) ^ (b[15] & b[16]) ^
          (b[25] & b[53]) ^ (b[35] & b[42]) ^ (b[55] & b[58]) ^
          (b[20] & b[22] & b[23]) ^ (b[62] & b[68] & b[72]) ^
          (b[77] & b[80] & b[81] & b[83]);
    return lin ^ hi;
  endfunction

  function automatic logic out_bit(input logic [S_LEN-1:0] s,
                                   input logic [B_LEN-1:0] b);
    logic l_part, q_part, t_part, tp_part;
    l_part  = b[7] ^ b[11] ^ b[30] ^ b[40] ^ b[45] ^ b[54] ^ b[71];
    q_part  = (b[4] & b[21]) ^ (b[9] & b[52]) ^ (b[18] & b[37]) ^ (b[44] & b[76]);
    t_part  = b[5] ^ (b[8] & b[82]) ^ (b[34] & b[67] & b[73]) ^
              (b[2] & b[28] & b[41] & b[65]) ^
              (b[13] & b[29] & b[50] & b[64] & b[75]) ^
              (b[6] & b[14] & b[26] & b[32] & b[47] & b[61]) ^
              (b[1] & b[19] & b[27] & b[43] & b[57] & b[66] & b[78]);
    tp_part = s[23] ^ (s[3] & s[16]) ^ (s[9] & s[13] & b[48]) ^
              (s[1] & s[24] & b[38] & b[63]);
    return l_part ^ q_part ^ t_part ^ tp_part;
  endfunction
endpackage

// File: rtl/kscore_sreg.sv
module kscore_sreg #(
  parameter int W         = 31,
  parameter bit FORCE_TOP = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         xadd_en,
  input  logic [W-1:0] xadd_val,
  input  logic         step_en,
  input  logic         fb_bit,
  output logic [W-1:0] q
);
  logic [W-1:0] xadd_res;
  logic [W-1:0] shift_res;

  generate
    if (FORCE_TOP) begin : g_force
      assign xadd_res = {1'b1, q[W-2:0] ^ xadd_val[W-2:0]};
    end else begin : g_plain
      assign xadd_res = q ^ xadd_val;
    end
  endgenerate

  assign shift_res = {fb_bit, q[W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= load_val;
    else if (xadd_en) q <= xadd_res;
    else if (step_en) q <= shift_res;
  end
endmodule

// File: rtl/kscore_fbnet.sv
module kscore_fbnet
  import kscore_pkg::*;
(
  input  logic [S_LEN-1:0] s,
  input  logic [B_LEN-1:0] b,
  input  logic             z,
  input  logic             mix_mode,
  output logic             s_fb_core,
  output logic             b_fb_core,
  output logic             s_fb,
  output logic             b_fb
);
  logic inject;

  assign s_fb_core = f1_next(s);
  assign b_fb_core = s[0] ^ f2_next(b);
  assign inject    = mix_mode & z;
  assign s_fb      = s_fb_core ^ inject;
  assign b_fb      = b_fb_core ^ inject;
endmodule

// File: rtl/kscore_outfn.sv
module kscore_outfn
  import kscore_pkg::*;
(
  input  logic [S_LEN-1:0] s,
  input  logic [B_LEN-1:0] b,
  output logic             z
);
  assign z = out_bit(s, b);
endmodule

// File: rtl/kscore_dual_nfsr.sv
module kscore_dual_nfsr
  import kscore_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [S_LEN-1:0]   load_s,
  input  logic [B_LEN-1:0]   load_b,
  input  logic               kadd_en,
  input  logic [KEY_LEN-1:0] kadd_val,
  input  logic               step_en,
  input  logic               mix_mode,
  output logic               z_out,
  output logic [S_LEN-1:0]   state_s,
  output logic [B_LEN-1:0]   state_b
);
  logic s_fb_core, b_fb_core, s_fb, b_fb;
  logic [S_LEN-1:0] s_key;

  assign s_key = {1'b0, kadd_val[KEY_LEN-1:B_LEN]};

  kscore_outfn u_out (.s(state_s), .b(state_b), .z(z_out));

  kscore_fbnet u_fb (
    .s(state_s), .b(state_b), .z(z_out), .mix_mode(mix_mode),
    .s_fb_core(s_fb_core), .b_fb_core(b_fb_core), .s_fb(s_fb), .b_fb(b_fb)
  );

  kscore_sreg #(.W(S_LEN), .FORCE_TOP(1'b1)) u_sreg_s (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_s),
    .xadd_en(kadd_en), .xadd_val(s_key), .step_en(step_en),
    .fb_bit(s_fb), .q(state_s)
  );

  kscore_sreg #(.W(B_LEN), .FORCE_TOP(1'b0)) u_sreg_b (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_b),
    .xadd_en(kadd_en), .xadd_val(kadd_val[B_LEN-1:0]), .step_en(step_en),
    .fb_bit(b_fb), .q(state_b)
  );
endmodule

// File: rtl/kscore_dual_nfsr_chk.sv
module kscore_dual_nfsr_chk
  import kscore_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               load_en,
  input logic [S_LEN-1:0]   load_s,
  input logic [B_LEN-1:0]   load_b,
  input logic               kadd_en,
  input logic [KEY_LEN-1:0] kadd_val,
  input logic               step_en,
  input logic               mix_mode,
  input logic               z_out,
  input logic [S_LEN-1:0]   state_s,
  input logic [B_LEN-1:0]   state_b,
  input logic               s_fb_core,
  input logic               b_fb_core
);
  logic only_step, idle;
  assign only_step = step_en & ~load_en & ~kadd_en;
  assign idle      = ~step_en & ~load_en & ~kadd_en;

  a_r2_s_shift: assert property (@(posedge clk) disable iff (!rst_n)
    only_step |=> state_s == {$past(s_fb_core ^ (mix_mode & z_out)), $past(state_s[S_LEN-1:1])});

  a_r3_b_shift: assert property (@(posedge clk) disable iff (!rst_n)
    only_step |=> state_b == {$past(b_fb_core ^ (mix_mode & z_out)), $past(state_b[B_LEN-1:1])});

  a_r4_zero_state: assert property (@(posedge clk) disable iff (!rst_n)
    (state_s == '0 && state_b == '0) |-> !z_out);

  a_r5_mix_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (only_step && mix_mode) |=>
      (state_s[S_LEN-1] ^ state_b[B_LEN-1]) == $past(s_fb_core ^ b_fb_core));

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (state_s == $past(load_s)) && (state_b == $past(load_b)));

  a_r7_key_add: assert property (@(posedge clk) disable iff (!rst_n)
    (kadd_en && !load_en) |=> state_s[S_LEN-1] &&
      (state_b == $past(state_b ^ kadd_val[B_LEN-1:0])) &&
      (state_s[S_LEN-2:0] == $past(state_s[S_LEN-2:0] ^ kadd_val[KEY_LEN-1:B_LEN])));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(state_s) && $stable(state_b));
endmodule

bind kscore_dual_nfsr kscore_dual_nfsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_s(load_s), .load_b(load_b),
  .kadd_en(kadd_en), .kadd_val(kadd_val), .step_en(step_en), .mix_mode(mix_mode),
  .z_out(z_out), .state_s(state_s), .state_b(state_b),
  .s_fb_core(s_fb_core), .b_fb_core(b_fb_core)
);

// File: tb/kscore_dual_nfsr_tb_top.sv
module kscore_dual_nfsr_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic load_en, kadd_en, step_en, mix_mode;
  logic [30:0] load_s;
  logic [89:0] load_b;
  logic [119:0] kadd_val;
  logic z_out;
  logic [30:0] state_s;
  logic [89:0] state_b;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_cnt = 0;

  bit [30:0] ms;
  bit [89:0] mb;

  // Monomial tables: B index j as j, S index i as 100+i, -1 pads.
  localparam int F1T [32][4] = '{
    '{0,-1,-1,-1}, '{2,-1,-1,-1}, '{5,-1,-1,-1}, '{6,-1,-1,-1}, '{15,-1,-1,-1},
    '{17,-1,-1,-1}, '{18,-1,-1,-1}, '{20,-1,-1,-1}, '{25,-1,-1,-1},
    '{8,18,-1,-1}, '{8,20,-1,-1}, '{12,21,-1,-1}, '{14,19,-1,-1}, '{17,21,-1,-1},
    '{20,22,-1,-1},
    '{4,12,22,-1}, '{8,18,22,-1}, '{4,19,22,-1}, '{7,20,21,-1}, '{8,20,22,-1},
    '{12,19,22,-1}, '{20,21,22,-1},
    '{4,7,12,21}, '{4,7,19,21}, '{4,12,21,22}, '{4,19,21,22}, '{7,8,18,21},
    '{7,8,20,21}, '{7,12,19,21}, '{8,18,21,22}, '{8,20,21,22}, '{12,19,21,22}};

  localparam int F2T [15][4] = '{
    '{0,-1,-1,-1}, '{24,-1,-1,-1}, '{49,-1,-1,-1}, '{79,-1,-1,-1}, '{84,-1,-1,-1},
    '{3,59,-1,-1}, '{60,74,-1,-1}, '{10,12,-1,-1}, '{15,16,-1,-1}, '{25,53,-1,-1},
    '{35,42,-1,-1}, '{55,58,-1,-1}, '{20,22,23,-1}, '{62,68,72,-1}, '{77,80,81,83}};

  localparam int ZT [22][7] = '{
    '{7,-1,-1,-1,-1,-1,-1}, '{11,-1,-1,-1,-1,-1,-1}, '{30,-1,-1,-1,-1,-1,-1},
    '{40,-1,-1,-1,-1,-1,-1}, '{45,-1,-1,-1,-1,-1,-1}, '{54,-1,-1,-1,-1,-1,-1},
    '{71,-1,-1,-1,-1,-1,-1},
    '{4,21,-1,-1,-1,-1,-1}, '{9,52,-1,-1,-1,-1,-1}, '{18,37,-1,-1,-1,-1,-1},
    '{44,76,-1,-1,-1,-1,-1},
    '{5,-1,-1,-1,-1,-1,-1}, '{8,82,-1,-1,-1,-1,-1}, '{34,67,73,-1,-1,-1,-1},
    '{2,28,41,65,-1,-1,-1}, '{13,29,50,64,75,-1,-1}, '{6,14,26,32,47,61,-1},
    '{1,19,27,43,57,66,78},
    '{123,-1,-1,-1,-1,-1,-1}, '{103,116,-1,-1,-1,-1,-1}, '{109,113,48,-1,-1,-1,-1},
    '{101,124,38,63,-1,-1,-1}};

  kscore_dual_nfsr dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_s(load_s), .load_b(load_b),
    .kadd_en(kadd_en), .kadd_val(kadd_val), .step_en(step_en), .mix_mode(mix_mode),
    .z_out(z_out), .state_s(state_s), .state_b(state_b)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic bit gb(int code);
    if (code >= 100) return ms[code-100];
    return mb[code];
  endfunction

  function automatic bit ref_f1();
    bit acc = 0;
    for (int r = 0; r < 32; r++) begin
      bit p = 1;
      for (int k = 0; k < 4; k++) if (F1T[r][k] >= 0) p &= ms[F1T[r][k]];
      acc ^= p;
    end
    return acc;
  endfunction

  function automatic bit ref_f2();
    bit acc = 0;
    for (int r = 0; r < 15; r++) begin
      bit p = 1;
      for (int k = 0; k < 4; k++) if (F2T[r][k] >= 0) p &= mb[F2T[r][k]];
      acc ^= p;
    end
    return acc;
  endfunction

  function automatic bit ref_z();
    bit acc = 0;
    for (int r = 0; r < 22; r++) begin
      bit p = 1;
      for (int k = 0; k < 7; k++) if (ZT[r][k] >= 0) p &= gb(ZT[r][k]);
      acc ^= p;
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, check z, advance model, check state at next negedge.
  task automatic cyc(input bit st, input bit md, input bit ld, input bit ka,
                     input bit [30:0] ls, input bit [89:0] lb, input bit [119:0] kv,
                     input string req);
    bit zz, n1, n2;
    step_en = st; mix_mode = md; load_en = ld; kadd_en = ka;
    load_s = ls; load_b = lb; kadd_val = kv;
    #1;
    zz = ref_z();
    check(z_out === zz, md ? "R4/R5 z" : "R4 z", {127'b0, z_out}, {127'b0, zz});
    if (ld) begin
      ms = ls; mb = lb;
    end else if (ka) begin
      mb = mb ^ kv[89:0];
      ms = {1'b1, ms[29:0] ^ kv[119:90]};
    end else if (st) begin
      n1 = ref_f1() ^ (md & zz);
      n2 = ms[0] ^ ref_f2() ^ (md & zz);
      ms = {n1, ms[30:1]};
      mb = {n2, mb[89:1]};
    end
    @(negedge clk);
    check(state_s === ms, {req, " S"}, {97'b0, state_s}, {97'b0, ms});
    check(state_b === mb, {req, " B"}, {38'b0, state_b}, {38'b0, mb});
  endtask

  function automatic bit [119:0] rnd120();
    return {$urandom, $urandom, $urandom, $urandom} >> 8;
  endfunction

  initial begin
    bit [119:0] r;
    rst_n = 1'b0; load_en = 0; kadd_en = 0; step_en = 0; mix_mode = 0;
    load_s = '0; load_b = '0; kadd_val = '0;
    ms = '0; mb = '0;
    repeat (3) @(negedge clk);
    // R1: cleared state and zero output
    check(state_s === 31'b0, "R1 S reset", {97'b0, state_s}, 128'b0);
    check(state_b === 90'b0, "R1 B reset", {38'b0, state_b}, 128'b0);
    check(z_out === 1'b0, "R1 z reset", {127'b0, z_out}, 128'b0);
    rst_n = 1'b1;

    // R2/R3: all-zero state is a fixed point
    repeat (4) cyc(1, 0, 0, 0, '0, '0, '0, "R2/R3 zero");

    // R6 then R2/R3/R4 normal mode
    r = rnd120();
    cyc(0, 0, 1, 0, r[30:0], {r[119:60], r[29:0]}, '0, "R6 load");
    repeat (150) cyc(1, 0, 0, 0, '0, '0, '0, "R2/R3 normal");

    // R5 mixing mode
    r = rnd120();
    cyc(0, 1, 1, 0, r[119:89], r[89:0], '0, "R6 load");
    repeat (150) cyc(1, 1, 0, 0, '0, '0, '0, "R5 mix");

    // R7 key add then normal steps
    r = rnd120();
    cyc(0, 0, 0, 1, '0, '0, r, "R7 kadd");
    repeat (40) cyc(1, 0, 0, 0, '0, '0, '0, "R2/R3 after kadd");

    // R6 priority over key add and step; R7 priority over step
    r = rnd120();
    cyc(1, 1, 1, 1, r[30:0], r[119:30], rnd120(), "R6 priority");
    cyc(1, 1, 0, 1, '0, '0, rnd120(), "R7 priority");

    // R8 idle with mode toggling
    for (int i = 0; i < 6; i++) cyc(0, i[0], 0, 0, '1, '1, '1, "R8 hold");

    // All-ones pattern, mixing then normal
    cyc(0, 0, 1, 0, '1, '1, '0, "R6 ones");
    repeat (30) cyc(1, 1, 0, 0, '0, '0, '0, "R5 ones mix");
    repeat (30) cyc(1, 0, 0, 0, '0, '0, '0, "R2/R3 ones");

    // Key add into zero state, then mixing
    cyc(0, 0, 1, 0, '0, '0, '0, "R6 zero");
    cyc(0, 0, 0, 1, '0, '0, '0, "R7 zero key");
    repeat (20) cyc(1, 1, 0, 0, '0, '0, '0, "R5 after kadd");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule